// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block watches the destination address of a received frame one bit per cycle, in the order the bits come off the wire, and decides whether the frame should be kept. It holds the address against a programmable station address, spots the all-ones broadcast address and multicast addresses, and can pass multicast addresses through a 64-entry hash table. The table is indexed by six bits of a CRC-32 that is computed over the address bits alone.

A two-bit mode input sets the acceptance policy. A separate flag lets every multicast address through without using the table. The receive path pulses `frame_start` before each frame and then presents address bits with `bit_valid`. The block raises `early_abort` as soon as a rejection is certain, so that the receive path can stop writing the frame. It gives a one-cycle `decision_valid` with `accept` after the 48th bit. The mode, flag, station address and hash table are held stable during a frame.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, and in the cycle after a `frame_start` pulse, `early_abort`, `decision_valid` and `accept` are all 0. A `frame_start` discards any partly received address.
- R2: Address bit k, counting from 0 in arrival order, is compared with `station_addr[k]`. The station address therefore holds its first byte in bits 7:0, LSB first. An address equal to `station_addr` is a station hit.
- R3: An address whose 48 bits are all 1 is broadcast.
- R4: An address is multicast when its first received bit (bit 0) is 1.
- R5: The CRC register is preset to 0xFFFFFFFF. For each address bit d, it computes f = crc[31] ^ d, shifts left by one with data entering at bit 0, and XORs in 0x04C11DB7 when f is 1. After 48 bits the byte select is {crc[0],crc[1],crc[2]} and the bit select is {crc[3],crc[4],crc[5]}, with crc[0] and crc[3] as the MSBs. The filter bit is `hash_table[8*byte+bit]`, and a multicast address passes the table when that bit is 1.
- R6: `mode` encoding: 00 rejects every frame, 01 accepts every frame, 10 accepts a station hit or broadcast, 11 accepts a station hit, broadcast, or a multicast address that passes the multicast rule.
- R7: In mode 11 with `mcast_all`=1, every multicast address passes the multicast rule. With `mcast_all`=0, a multicast address passes only through the hash table.
- R8: `early_abort` is high for exactly one cycle per rejected frame. That cycle is the one after the bit that makes rejection certain. In mode 10 this is the first bit at which both a station miss and a broadcast miss are known. In mode 11 it is the same bit, provided bit 0 was 0. Otherwise it is the cycle of `decision_valid`. Accepted frames never raise it.
- R9: `decision_valid` is high for exactly one cycle, the cycle after the 48th address bit is taken. In that cycle `accept` gives the decision, and `accept` is 0 in every other cycle. Bits presented after the 48th and before the next `frame_start` have no effect.
- R10: In mode 00, `early_abort` is high in the cycle after the first address bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | Clears the per-frame state before a new address |
| bit_valid | input | 1 | `bit_in` carries an address bit this cycle |
| bit_in | input | 1 | Address bit, in arrival order |
| mode | input | 2 | Acceptance policy (see R6) |
| mcast_all | input | 1 | Accept all multicast addresses without the table |
| station_addr | input | 48 | Own address, bit k compared with arrival bit k |
| hash_table | input | 64 | Multicast filter bits, indexed 8*byte+bit |
| early_abort | output | 1 | One-cycle pulse when rejection becomes certain |
| decision_valid | output | 1 | One-cycle pulse after the 48th address bit |
| accept | output | 1 | Frame accepted, qualified by `decision_valid` |

## Verification
Every result is due exactly one cycle after the edge that takes the address bit deciding it. `early_abort` follows the deciding bit, and `decision_valid` with `accept` follows the 48th bit. The bench drives bits on the falling edge and samples all three outputs on the next falling edge. For each bit it compares them with the value that a bench model of the requirements predicts for that bit index. Random idle gaps between bits let the bench confirm that a pulse lasts only one cycle and that an idle cycle yields no result. Extra bits after the 48th are checked to leave the outputs quiet.

// File: rtl/dst_filt_pkg.sv
// Package: shared constants and the match-mode type for the address filter.
// Assumes the default widths of a standard 48-bit MAC address and CRC-32.
package dst_filt_pkg;
    localparam int          ADDR_W   = 48;
    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
    localparam int          TABLE_W  = 64;

    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,   // reject everything
        MODE_ALL = 2'b01,   // promiscuous
        MODE_SB  = 2'b10,   // station or broadcast
        MODE_SBM = 2'b11    // station, broadcast or multicast
    } match_mode_e;
endpackage

// File: rtl/dst_addr_match.sv
// Module: dst_addr_match
// Counts the arriving address bits and tracks station-miss, broadcast-miss
// and multicast flags. Assumes one bit per cycle when bit_valid is high;
// bits beyond the last address bit are refused until clear.
module dst_addr_match #(
    parameter int ADDR_W = 48,
    localparam int CNT_W = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic [ADDR_W-1:0] station_addr,
    output logic              take,
    output logic              started,
    output logic              done,
    output logic              st_miss,
    output logic              bc_miss,
    output logic              mcast
);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(ADDR_W);

    logic [CNT_W-1:0] cnt_q;
    logic             st_miss_q, bc_miss_q, mcast_q;

    // A bit is taken only while the address is still incomplete
    assign take    = bit_valid && !clear && (cnt_q != CNT_END);
    assign started = (cnt_q != '0);
    assign done    = (cnt_q == CNT_END);
    assign st_miss = st_miss_q;
    assign bc_miss = bc_miss_q;
    assign mcast   = mcast_q;

    // Bit counter and the three per-frame address flags
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q     <= '0;
            st_miss_q <= 1'b0;
            bc_miss_q <= 1'b0;
            mcast_q   <= 1'b0;
        end else if (take) begin
            cnt_q     <= cnt_q + 1'b1;
            st_miss_q <= st_miss_q | (bit_in != station_addr[cnt_q]);
            bc_miss_q <= bc_miss_q | !bit_in;
            if (cnt_q == '0) mcast_q <= bit_in;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_END);                                                // R9
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        done && !clear |=> done);                                         // R9
endmodule

// File: rtl/dst_crc_hash.sv
// Module: dst_crc_hash
// Runs a bit-serial CRC over the address bits and looks up the multicast
// filter bit selected by the low CRC bits. Assumes TABLE_W is a power of
// two no larger than 2**CRC_W; crc[0] is the most significant select bit.
module dst_crc_hash #(
    parameter int          CRC_W   = 32,
    parameter logic [31:0] POLY    = 32'h04C11DB7,
    parameter int          TABLE_W = 64,
    localparam int         SEL_W   = $clog2(TABLE_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               shift,
    input  logic               din,
    input  logic [TABLE_W-1:0] hash_table,
    output logic               hash_hit
);
    logic [CRC_W-1:0] crc_q, crc_nxt;
    logic             fb;
    logic [SEL_W-1:0] hash_idx;

    // Next CRC value for one incoming bit, data entering at bit 0
    always_comb begin
        fb      = crc_q[CRC_W-1] ^ din;
        crc_nxt = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY[CRC_W-1:0] : '0);
    end

    // CRC register, preset to all ones at each frame
    always_ff @(posedge clk) begin
        if (!rst_n || clear) crc_q <= '1;
        else if (shift)      crc_q <= crc_nxt;
    end

    // Reverse the low CRC bits into the table index: crc[0] becomes the MSB
    for (genvar g = 0; g < SEL_W; g++) begin : g_idx
        assign hash_idx[SEL_W-1-g] = crc_q[g];
    end

    assign hash_hit = hash_table[hash_idx];

    AST_CRC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !shift && !clear |=> $stable(crc_q));                             // R5
endmodule

// File: rtl/dst_policy.sv
// Module: dst_policy
// Turns the address flags and hash result into an early-abort pulse and a
// final decision according to the match mode. Assumes mode and mcast_all
// stay stable during a frame.
module dst_policy
    import dst_filt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic [1:0] mode,
    input  logic       mcast_all,
    input  logic       started,
    input  logic       done,
    input  logic       st_miss,
    input  logic       bc_miss,
    input  logic       mcast,
    input  logic       hash_hit,
    output logic       early_abort,
    output logic       decision_valid,
    output logic       accept
);
    match_mode_e mode_e;
    logic        mc_pass, final_ok, early_rej, rej_known;
    logic        aborted_q, reported_q;

    assign mode_e = match_mode_e'(mode);

    // Acceptance at the end of the address and certainty of rejection so far
    always_comb begin
        mc_pass  = mcast && (mcast_all || hash_hit);
        final_ok = 1'b0;
        early_rej = 1'b0;
        case (mode_e)
            MODE_OFF: begin
                final_ok  = 1'b0;
                early_rej = started;
            end
            MODE_ALL: begin
                final_ok  = 1'b1;
                early_rej = 1'b0;
            end
            MODE_SB: begin
                final_ok  = !st_miss || !bc_miss;
                early_rej = st_miss && bc_miss;
            end
            default: begin
                final_ok  = !st_miss || !bc_miss || mc_pass;
                early_rej = st_miss && bc_miss && !mcast;
            end
        endcase
        rej_known = early_rej || (done && !final_ok);
    end

    assign early_abort    = rej_known && !aborted_q;
    assign decision_valid = done && !reported_q;
    assign accept         = decision_valid && final_ok;

    // One-shot memory for the abort pulse and the decision pulse
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            aborted_q  <= 1'b0;
            reported_q <= 1'b0;
        end else begin
            aborted_q  <= aborted_q | rej_known;
            reported_q <= reported_q | done;
        end
    end

    AST_ABORT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        early_abort && !clear |=> !early_abort);                          // R8
    AST_DECIDE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid && !clear |=> !decision_valid);                    // R9
    AST_ACCEPT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !aborted_q && !early_abort);                           // R8
    AST_OFF_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_e == MODE_OFF |-> !accept);                                  // R10
    AST_PROMISC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_e == MODE_ALL |-> !early_abort);                             // R6
endmodule

// File: rtl/dst_addr_filter.sv
// Module: dst_addr_filter (top)
// Destination address filter: bit counter and flags, CRC hash lookup and
// acceptance policy. Assumes frame_start precedes each address and that
// configuration inputs are stable while an address is received.
module dst_addr_filter
    import dst_filt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                bit_valid,
    input  logic                bit_in,
    input  logic [1:0]          mode,
    input  logic                mcast_all,
    input  logic [ADDR_W-1:0]   station_addr,
    input  logic [TABLE_W-1:0]  hash_table,
    output logic                early_abort,
    output logic                decision_valid,
    output logic                accept
);
    logic take, started, done, st_miss, bc_miss, mcast, hash_hit;

    dst_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .clk(clk), .rst_n(rst_n), .clear(frame_start),
        .bit_valid(bit_valid), .bit_in(bit_in), .station_addr(station_addr),
        .take(take), .started(started), .done(done),
        .st_miss(st_miss), .bc_miss(bc_miss), .mcast(mcast)
    );

    dst_crc_hash #(.CRC_W(CRC_W), .POLY(CRC_POLY), .TABLE_W(TABLE_W)) u_hash (
        .clk(clk), .rst_n(rst_n), .clear(frame_start),
        .shift(take), .din(bit_in), .hash_table(hash_table),
        .hash_hit(hash_hit)
    );

    dst_policy u_policy (
        .clk(clk), .rst_n(rst_n), .clear(frame_start),
        .mode(mode), .mcast_all(mcast_all),
        .started(started), .done(done),
        .st_miss(st_miss), .bc_miss(bc_miss), .mcast(mcast),
        .hash_hit(hash_hit),
        .early_abort(early_abort), .decision_valid(decision_valid),
        .accept(accept)
    );

    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !decision_valid && !early_abort);                 // R1
endmodule

// File: tb/test_dst_addr_filter.sv
module test_dst_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n, frame_start, bit_valid, bit_in, mcast_all;
    logic [1:0]  mode;
    logic [47:0] station_addr;
    logic [63:0] hash_table;
    logic        early_abort, decision_valid, accept;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    dst_addr_filter i_dst_addr_filter (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .bit_valid(bit_valid), .bit_in(bit_in), .mode(mode),
        .mcast_all(mcast_all), .station_addr(station_addr),
        .hash_table(hash_table), .early_abort(early_abort),
        .decision_valid(decision_valid), .accept(accept)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Hash index per R5
    function automatic int hash_index(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            logic f = c[31] ^ a[i];
            c = {c[30:0], 1'b0};
            if (f) c = c ^ 32'h04C1_1DB7;
        end
        return {c[0], c[1], c[2]} * 8 + {c[3], c[4], c[5]};
    endfunction

    // Final decision per R2, R3, R4, R6, R7
    function automatic bit exp_accept(input logic [47:0] a);
        bit st = (a == station_addr);
        bit bc = (a == 48'hFFFF_FFFF_FFFF);
        bit mc = a[0];
        bit mp = mc && (mcast_all || hash_table[hash_index(a)]);
        case (mode)
            2'b00:   return 1'b0;
            2'b01:   return 1'b1;
            2'b10:   return st || bc;
            default: return st || bc || mp;
        endcase
    endfunction

    // Bit index after which early_abort is due, -1 for none (R8, R10)
    function automatic int exp_abort_idx(input logic [47:0] a);
        bit sm = 1'b0, bm = 1'b0;
        if (mode == 2'b00) return 0;
        if (mode == 2'b01) return -1;
        for (int i = 0; i < 48; i++) begin
            sm |= (a[i] != station_addr[i]);
            bm |= !a[i];
            if (sm && bm && (mode == 2'b10 || !a[0])) return i;
        end
        return exp_accept(a) ? -1 : 47;
    endfunction

    task automatic pulse_start();
        @(negedge clk);
        frame_start = 1'b1; bit_valid = 1'b0;
        @(negedge clk);
        frame_start = 1'b0;
        chk(!early_abort && !decision_valid && !accept, "R1",
            "outputs after frame_start",
            {early_abort, decision_valid, accept}, 0);
    endtask

    task automatic run_frame(input logic [47:0] a, input bit gaps, input string tag);
        int  ai = exp_abort_idx(a);
        bit  ea = exp_accept(a);
        pulse_start();
        for (int i = 0; i < 48; i++) begin
            if (gaps && ($urandom % 4 == 0)) begin
                bit_valid = 1'b0;
                @(negedge clk);
                chk(!early_abort && !decision_valid, "R9", "idle cycle output",
                    {early_abort, decision_valid}, 0);
            end
            bit_valid = 1'b1; bit_in = a[i];
            @(negedge clk);
            bit_valid = 1'b0;
            chk(early_abort == (i == ai), "R8", {tag, " early_abort"},
                early_abort, (i == ai));
            chk(decision_valid == (i == 47), "R9", {tag, " decision_valid"},
                decision_valid, (i == 47));
            chk(accept == ((i == 47) && ea), "R6", {tag, " accept"},
                accept, (i == 47) && ea);
        end
        // Extra bits past the address have no effect
        for (int k = 0; k < 3; k++) begin
            bit_valid = 1'b1; bit_in = $urandom % 2;
            @(negedge clk);
            chk(!early_abort && !decision_valid && !accept, "R9",
                {tag, " bits beyond address"},
                {early_abort, decision_valid, accept}, 0);
        end
        bit_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [47:0] a;
        process::self().srandom(32'd1234);
        rst_n = 1'b0; frame_start = 1'b0; bit_valid = 1'b0; bit_in = 1'b0;
        mode = 2'b10; mcast_all = 1'b0;
        station_addr = 48'h5634_1200_AB02;
        hash_table = '0;
        repeat (3) @(negedge clk);
        chk(!early_abort && !decision_valid && !accept, "R1", "reset outputs",
            {early_abort, decision_valid, accept}, 0);
        rst_n = 1'b1;

        // Directed corner cases
        run_frame(station_addr, 0, "R2 station hit");
        run_frame(station_addr ^ (48'h1 << 47), 0, "R2 last bit differs");
        run_frame(48'hFFFF_FFFF_FFFF, 0, "R3 broadcast");
        run_frame(48'hFFFF_FFFF_FFFE, 0, "R3 near broadcast");
        mode = 2'b11; mcast_all = 1'b1;
        run_frame(48'h0000_0000_0001, 0, "R7 mcast_all");
        run_frame(48'h0000_0000_0010, 0, "R4 unicast mode 11");
        mcast_all = 1'b0;
        a = 48'h3C00_5E00_0001;
        hash_table = 64'h1 << hash_index(a);
        run_frame(a, 0, "R5 hash hit");
        hash_table = ~hash_table;
        run_frame(a, 0, "R5 hash miss");
        mode = 2'b00;
        run_frame(station_addr, 0, "R10 disabled");
        mode = 2'b01;
        run_frame(48'h1234_5678_9ABC, 0, "R6 promiscuous");
        // Partial frame then restart (R1)
        mode = 2'b10;
        pulse_start();
        for (int i = 0; i < 10; i++) begin
            bit_valid = 1'b1; bit_in = 1'b0;
            @(negedge clk);
        end
        bit_valid = 1'b0;
        run_frame(station_addr, 0, "R1 restart after partial");

        // Constrained random frames
        for (int n = 0; n < 300; n++) begin
            int sel = $urandom % 20;
            mode = 2'($urandom);
            mcast_all = 1'($urandom);
            hash_table = {$urandom, $urandom};
            station_addr = {16'($urandom), $urandom};
            if (sel < 5)       a = station_addr;
            else if (sel < 8)  a = 48'hFFFF_FFFF_FFFF;
            else if (sel < 10) a = station_addr ^ (48'h1 << ($urandom % 48));
            else               a = {16'($urandom), $urandom};
            run_frame(a, 1, "random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule